// File: doc/BRIEF.md
# Virtual-to-Physical Address Translation and Protection Controller

This block sits between a processor-side request port and a single memory port. It takes a 14-bit virtual address, splits it into an 8-bit virtual page number and a 6-bit offset (64-byte pages), and produces a 12-bit physical address made of a 6-bit physical page number and the unchanged offset. A small fully associative translation buffer is probed first. On a miss, the controller reads one page table entry from a flat, single-level table at a configurable base. It installs the entry only if the entry is valid, and then performs the data access.

Every access is checked against the entry's valid bit and its read, write and execute permissions. A failing check never reaches memory. Instead, a fault is reported with its kind, the virtual address and the access type, and it is held until the processor acknowledges it. A flush input clears the translation buffer, for use when the address space changes. Only one request is in flight at a time.

Top module: `mmu_xlate`

## Requirements
- R1: After reset, req_ready is 1 and mem_valid, rsp_valid and flt_valid are 0.
- R2: A permitted access drives mem_addr = {PPN, VA[5:0]}, with mem_we = 1 and mem_wdata = req_wdata for a write (type 1), and mem_we = 0 otherwise. The word on mem_rdata in the handshake cycle is returned on rsp_rdata, with a one-cycle rsp_valid pulse.
- R3: On a buffer miss, exactly one read (mem_we = 0) is made at PT_BASE + VPN*2 before any data access. The entry layout is bits [5:0] PPN, bit 6 valid, bit 7 read, bit 8 write and bit 9 execute.
- R4: On a buffer hit, no table read is made. The data access is the only memory transfer.
- R5: A fetched entry with valid = 0 raises a fault with flt_kind = 0 (page fault). No data access is made, and the buffer is not filled, so a repeat of the access reads the table again.
- R6: A read (type 0) needs the read bit, a write (type 1) needs the write bit, and a fetch (type 2) needs the execute bit. Type 3 never passes. A failure raises flt_kind = 1 (protection) with no data access. A valid entry fetched by a walk is still installed, so a repeat hits without a table read.
- R7: flt_valid, flt_kind, flt_va and flt_type hold until flt_ack is sampled high. req_ready stays 0 meanwhile, and the controller returns to idle on the edge after the acknowledge.
- R8: A tlb_flush pulse invalidates every buffer entry. The next access to any page reads the table again and uses the entry currently in memory.
- R9: The buffer holds TLB_ENTRIES translations. When it is full, a new fill replaces the oldest fill. No page is ever held twice.
- R10: mem_valid and mem_addr stay stable until mem_ready is seen. req_ready is 0 from acceptance until the response or the fault acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tlb_flush | input | 1 | Invalidate all translation buffer entries |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_va | input | 14 | Virtual address |
| req_type | input | 2 | 0 read, 1 write, 2 fetch |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle pulse, access completed |
| rsp_rdata | output | 16 | Data word returned by memory |
| flt_valid | output | 1 | Fault pending |
| flt_kind | output | 1 | 0 page fault, 1 protection fault |
| flt_va | output | 14 | Faulting virtual address |
| flt_type | output | 2 | Access type of faulting request |
| flt_ack | input | 1 | Processor acknowledges the fault |
| mem_valid | output | 1 | Memory transfer requested |
| mem_ready | input | 1 | Memory completes the transfer this cycle |
| mem_addr | output | 12 | Physical address |
| mem_we | output | 1 | Write enable |
| mem_wdata | output | 16 | Write data to memory |
| mem_rdata | input | 16 | Read data from memory, valid with mem_ready |

## Verification
The bench aims at a stale mapping that survives in the buffer after the table changes. A design without a working flush would keep returning the old physical page after the flush pulse. It then repeats accesses to pages that have page-faulted: a design that installs invalid entries would skip the second table read, or would translate through garbage. It also fills the buffer past capacity, which shows up as a missing or extra table read when the replacement order is wrong. Finally, it runs under a stalling memory, where an address that moves before mem_ready is seen would show up as a mismatched transfer, and it checks each permission bit against each access type.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_t;

  typedef enum logic {
    FLT_PAGE = 1'b0,
    FLT_PROT = 1'b1
  } flt_t;

  // permission triple as it sits above the valid bit in an entry
  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_WALK, ST_ACCESS, ST_FAULT
  } st_t;
endpackage

// File: rtl/mmu_perm.sv
module mmu_perm
  import mmu_pkg::*;
(
  input  acc_t  acc,
  input  perm_t perm,
  output logic  allow
);
  always_comb begin
    unique case (acc)
      ACC_READ:  allow = perm.r;
      ACC_WRITE: allow = perm.w;
      ACC_FETCH: allow = perm.x;
      default:   allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/mmu_tlb.sv
module mmu_tlb
  import mmu_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 8,
  parameter int PPN_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] probe_vpn,
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn,
  output perm_t            hit_perm,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  perm_t            fill_perm
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] ent_v;
  logic [ENTRIES-1:0] match;
  logic [VPN_W-1:0]   ent_tag  [ENTRIES];
  logic [PPN_W-1:0]   ent_ppn  [ENTRIES];
  perm_t              ent_perm [ENTRIES];
  logic [PTR_W-1:0]   ptr_q, ptr_d;
  logic               wr_en;

  assign wr_en = fill_en && !flush;

  genvar gi;
  generate
    for (gi = 0; gi < ENTRIES; gi++) begin : g_cmp
      assign match[gi] = ent_v[gi] && (ent_tag[gi] == probe_vpn);
    end
  endgenerate

  always_comb begin
    hit_ppn  = '0;
    hit_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        hit_ppn  = hit_ppn | ent_ppn[i];
        hit_perm = hit_perm | ent_perm[i];
      end
    end
  end
  assign hit = |match;

  // round-robin victim pointer, restarts on flush
  always_comb begin
    ptr_d = ptr_q;
    if (flush)
      ptr_d = '0;
    else if (wr_en)
      ptr_d = (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      ent_v <= '0;
    end else begin
      ptr_q <= ptr_d;
      for (int i = 0; i < ENTRIES; i++) begin
        if (flush)
          ent_v[i] <= 1'b0;
        else if (wr_en && (ptr_q == PTR_W'(i)))
          ent_v[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (wr_en && (ptr_q == PTR_W'(i))) begin
        ent_tag[i]  <= fill_vpn;
        ent_ppn[i]  <= fill_ppn;
        ent_perm[i] <= fill_perm;
      end
    end
  end

  // R9
  tlb_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
  import mmu_pkg::*;
#(
  parameter int VA_W        = 14,
  parameter int PA_W        = 12,
  parameter int OFF_W       = 6,
  parameter int DATA_W      = 16,
  parameter int TLB_ENTRIES = 4,
  parameter int PT_BASE     = 'h800,
  parameter int PTE_BYTES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tlb_flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [1:0]        req_type,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              flt_valid,
  output logic              flt_kind,
  output logic [VA_W-1:0]   flt_va,
  output logic [1:0]        flt_type,
  input  logic              flt_ack,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [PA_W-1:0]   mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int V_BIT = PPN_W;

  st_t               state_q, state_d;
  logic [VA_W-1:0]   va_q, va_d;
  acc_t              type_q, type_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [PPN_W-1:0]  ppn_q, ppn_d;
  flt_t              kind_q, kind_d;
  logic              rsp_q, rsp_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  logic [VPN_W-1:0]  vpn;
  logic              tlb_hit;
  logic [PPN_W-1:0]  tlb_ppn;
  perm_t             tlb_perm;
  logic              fill_en;
  logic [PPN_W-1:0]  pte_ppn;
  perm_t             pte_perm;
  logic              pte_v;
  perm_t             chk_perm;
  logic              allow;
  logic [PA_W-1:0]   pte_addr;

  assign vpn      = va_q[VA_W-1:OFF_W];
  assign pte_ppn  = mem_rdata[PPN_W-1:0];
  assign pte_v    = mem_rdata[V_BIT];
  assign pte_perm = perm_t'(mem_rdata[V_BIT+3:V_BIT+1]);
  assign chk_perm = (state_q == ST_WALK) ? pte_perm : tlb_perm;
  assign pte_addr = PA_W'(PT_BASE) + PA_W'(vpn) * PA_W'(PTE_BYTES);

  mmu_tlb #(.ENTRIES(TLB_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_tlb (
    .clk(clk), .rst_n(rst_n), .flush(tlb_flush),
    .probe_vpn(vpn), .hit(tlb_hit), .hit_ppn(tlb_ppn), .hit_perm(tlb_perm),
    .fill_en(fill_en), .fill_vpn(vpn), .fill_ppn(pte_ppn), .fill_perm(pte_perm)
  );

  mmu_perm u_perm (.acc(type_q), .perm(chk_perm), .allow(allow));

  always_comb begin
    state_d   = state_q;
    va_d      = va_q;
    type_d    = type_q;
    wdata_d   = wdata_q;
    ppn_d     = ppn_q;
    kind_d    = kind_q;
    rsp_d     = 1'b0;
    rdata_d   = rdata_q;
    fill_en   = 1'b0;
    mem_valid = 1'b0;
    mem_addr  = pte_addr;
    mem_we    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        va_d    = req_va;
        type_d  = acc_t'(req_type);
        wdata_d = req_wdata;
        state_d = ST_LOOKUP;
      end
      ST_LOOKUP: begin
        if (!tlb_hit) begin
          state_d = ST_WALK;
        end else if (allow) begin
          ppn_d   = tlb_ppn;
          state_d = ST_ACCESS;
        end else begin
          kind_d  = FLT_PROT;
          state_d = ST_FAULT;
        end
      end
      ST_WALK: begin
        mem_valid = 1'b1;
        if (mem_ready) begin
          if (!pte_v) begin
            kind_d  = FLT_PAGE;
            state_d = ST_FAULT;
          end else begin
            fill_en = 1'b1;
            ppn_d   = pte_ppn;
            kind_d  = FLT_PROT;
            state_d = allow ? ST_ACCESS : ST_FAULT;
          end
        end
      end
      ST_ACCESS: begin
        mem_valid = 1'b1;
        mem_addr  = {ppn_q, va_q[OFF_W-1:0]};
        mem_we    = (type_q == ACC_WRITE);
        if (mem_ready) begin
          rsp_d   = 1'b1;
          rdata_d = mem_rdata;
          state_d = ST_IDLE;
        end
      end
      ST_FAULT: if (flt_ack) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rsp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rsp_q   <= rsp_d;
    end
  end

  always_ff @(posedge clk) begin
    va_q    <= va_d;
    type_q  <= type_d;
    wdata_q <= wdata_d;
    ppn_q   <= ppn_d;
    kind_q  <= kind_d;
    rdata_q <= rdata_d;
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;
  assign flt_valid = (state_q == ST_FAULT);
  assign flt_kind  = kind_q;
  assign flt_va    = va_q;
  assign flt_type  = type_q;
  assign mem_wdata = wdata_q;

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we));
  // R7
  flt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid && !flt_ack |=> flt_valid && $stable(flt_va) && $stable(flt_kind) && $stable(flt_type));
  // R5
  flt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |-> !mem_valid && !req_ready && !rsp_valid);
  // R2
  rsp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(mem_valid && mem_ready));
  // R10
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && req_valid |=> !req_ready);
endmodule

// File: tb/tb_mmu_xlate.sv
module tb_mmu_xlate;
  localparam int TLB_N = 4;
  localparam int PTB   = 'h800;

  logic        clk, rst_n, tlb_flush;
  logic        req_valid, req_ready;
  logic [13:0] req_va;
  logic [1:0]  req_type;
  logic [15:0] req_wdata;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        flt_valid, flt_kind;
  logic [13:0] flt_va;
  logic [1:0]  flt_type;
  logic        flt_ack;
  logic        mem_valid, mem_ready, mem_we;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  mmu_xlate #(.TLB_ENTRIES(TLB_N), .PT_BASE(PTB)) dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  logic [15:0] mem [4096];
  bit stall_on = 0;
  int cyc = 0;

  // reference model state
  int          tv[$];
  logic [15:0] tp[$];
  int          ex_addr[$];
  bit          ex_we[$];
  int          ex_wd[$];
  string       ex_tag[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // memory model: drives ready/data away from the active edge, compares every transfer
  always @(negedge clk) begin
    cyc++;
    mem_ready = !stall_on || (cyc % 3 == 2);
    mem_rdata = mem[mem_addr];
    if (rst_n && mem_valid && mem_ready) begin
      if (ex_addr.size() == 0) begin
        chk(0, "R4", "unexpected memory transfer addr", int'(mem_addr), 0);
      end else begin
        chk(int'(mem_addr) == ex_addr[0], ex_tag[0], "transfer addr", int'(mem_addr), ex_addr[0]);
        chk(mem_we == ex_we[0], ex_tag[0], "transfer we", int'(mem_we), int'(ex_we[0]));
        if (ex_we[0]) begin
          chk(int'(mem_wdata) == ex_wd[0], "R2", "write data", int'(mem_wdata), ex_wd[0]);
          mem[mem_addr] = mem_wdata;
        end
        void'(ex_addr.pop_front()); void'(ex_we.pop_front());
        void'(ex_wd.pop_front());   void'(ex_tag.pop_front());
      end
    end
  end

  task automatic set_pte(input int vpn, input bit v, r, w, x, input int ppn);
    mem[PTB + vpn*2] = {6'b0, x, w, r, v, 6'(ppn)};
  endtask

  task automatic push_ex(input int a, input bit we, input int wd, input string tag);
    ex_addr.push_back(a); ex_we.push_back(we); ex_wd.push_back(wd); ex_tag.push_back(tag);
  endtask

  task automatic run_req(input int va, input int typ, input int wd, input string tag);
    int vpn, off, hi, pa, exp_rd;
    logic [15:0] pte;
    bit flt, kind, allow, seen;
    vpn = va >> 6; off = va & 63; hi = -1;
    foreach (tv[i]) if (tv[i] == vpn) hi = i;
    if (hi >= 0) pte = tp[hi];
    else begin
      push_ex(PTB + vpn*2, 0, 0, "R3");
      pte = mem[PTB + vpn*2];
      if (pte[6]) begin
        if (tv.size() == TLB_N) begin void'(tv.pop_front()); void'(tp.pop_front()); end
        tv.push_back(vpn); tp.push_back(pte);
      end
    end
    allow = (typ == 0) ? pte[7] : (typ == 1) ? pte[8] : (typ == 2) ? pte[9] : 1'b0;
    flt = !pte[6] || !allow;
    kind = pte[6];
    exp_rd = 0;
    if (!flt) begin
      pa = (int'(pte[5:0]) << 6) | off;
      exp_rd = int'(mem[pa]);
      push_ex(pa, typ == 1, wd, tag);
    end
    // issue
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_va = 14'(va); req_type = 2'(typ); req_wdata = 16'(wd);
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R10", "req_ready while busy", int'(req_ready), 0);
    seen = 0;
    for (int k = 0; k < 60 && !seen; k++) begin
      if (rsp_valid || flt_valid) seen = 1;
      else @(negedge clk);
    end
    chk(seen, tag, "completion seen", int'(seen), 1);
    if (!seen) return;
    chk(flt_valid == flt, tag, "fault flag", int'(flt_valid), int'(flt));
    if (flt && flt_valid) begin
      chk(flt_kind == kind, kind ? "R6" : "R5", "fault kind", int'(flt_kind), int'(kind));
      chk(int'(flt_va) == va, "R7", "fault va", int'(flt_va), va);
      chk(int'(flt_type) == typ, "R7", "fault type", int'(flt_type), typ);
      repeat (2) @(negedge clk);
      chk(flt_valid && int'(flt_va) == va && !req_ready, "R7", "fault held before ack",
          int'(flt_valid), 1);
      flt_ack = 1;
      @(negedge clk);
      flt_ack = 0;
      chk(!flt_valid && req_ready, "R7", "fault cleared after ack", int'(flt_valid), 0);
    end else if (!flt && rsp_valid && typ != 1) begin
      chk(int'(rsp_rdata) == exp_rd, "R2", "read data", int'(rsp_rdata), exp_rd);
    end
    chk(ex_addr.size() == 0, tag, "pending expected transfers", ex_addr.size(), 0);
    ex_addr.delete(); ex_we.delete(); ex_wd.delete(); ex_tag.delete();
  endtask

  task automatic do_flush();
    @(negedge clk);
    tlb_flush = 1;
    @(negedge clk);
    tlb_flush = 0;
    tv.delete(); tp.delete();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int a = 0; a < 4096; a++) mem[a] = 16'((a * 7) ^ 'h5A5A);
    for (int v = 0; v < 256; v++) mem[PTB + v*2] = 16'h0;
    rst_n = 0; tlb_flush = 0; req_valid = 0; req_va = 0; req_type = 0;
    req_wdata = 0; flt_ack = 0;
    repeat (3) @(negedge clk);
    // R1
    chk(req_ready == 1, "R1", "reset req_ready", int'(req_ready), 1);
    chk(mem_valid == 0, "R1", "reset mem_valid", int'(mem_valid), 0);
    chk(rsp_valid == 0, "R1", "reset rsp_valid", int'(rsp_valid), 0);
    chk(flt_valid == 0, "R1", "reset flt_valid", int'(flt_valid), 0);
    rst_n = 1;

    set_pte('h0F, 1, 1, 1, 0, 'h0D);
    set_pte('h02, 1, 1, 0, 1, 'h13);
    set_pte('h03, 0, 1, 1, 1, 'h04);
    set_pte('h05, 1, 1, 0, 0, 'h16);
    for (int v = 'h10; v < 'h16; v++) set_pte(v, 1, 1, 1, 0, v - 'h0F);

    run_req('h03D4, 0, 0, "R3");        // miss, PA 0x354
    run_req('h03C0, 0, 0, "R4");        // hit
    run_req('h03E0, 1, 'hBEEF, "R2");   // write, hit
    run_req('h03E0, 0, 0, "R2");        // read back
    run_req('h0085, 2, 0, "R2");        // fetch allowed, miss
    run_req('h0085, 1, 'h1111, "R6");   // write denied on hit
    run_req('h03D4, 2, 0, "R6");        // fetch denied on hit
    run_req('h03D4, 3, 0, "R6");        // reserved type
    run_req('h00C8, 0, 0, "R5");        // invalid page
    run_req('h00C8, 2, 0, "R5");        // walked again, not installed
    run_req('h0150, 1, 'h2222, "R6");   // walk then denied
    run_req('h0150, 0, 0, "R6");        // installed: hit
    run_req('h0400, 0, 0, "R9");        // fills 4th slot
    run_req('h0440, 0, 0, "R9");        // evicts oldest
    run_req('h03D4, 0, 0, "R9");        // evicted page walks again
    run_req('h0085, 2, 0, "R9");
    run_req('h0441, 0, 0, "R9");        // still held

    set_pte('h11, 1, 1, 1, 0, 'h07);
    run_req('h0442, 0, 0, "R8");        // stale mapping still used
    do_flush();
    run_req('h0443, 0, 0, "R8");        // new mapping after flush
    run_req('h03D5, 0, 0, "R8");

    stall_on = 1;
    run_req('h0480, 1, 'h3333, "R10");
    run_req('h0480, 0, 0, "R10");
    run_req('h00C9, 0, 0, "R10");
    run_req('h0151, 2, 0, "R10");
    stall_on = 0;
    run_req('h0500, 0, 0, "R3");

    repeat (3) @(negedge clk);
    summary();
  end
endmodule